// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Power-of-Two Prescaler

This block produces one pulse-width-modulated output. A free-running divider turns the system clock into a count tick at 1/2^p of the clock rate. A 16-bit counter steps on that tick and runs through one waveform period. The period length and the compare point come from two active registers. The compare register holds the number of counts the output stays *inactive* at the start of each period. As a result, the active time is the period minus the register value.

While the channel runs, new period and compare values are written into shadow registers. They move into the active registers only at a period boundary, so the waveform never shows a partly changed period. Each boundary that moves at least one shadow value raises a single-cycle event pulse for a shared interrupt block. A mode register holds the prescaler, the output polarity and a "linked" bit. When the linked bit is set, the two shadow values wait for each other and move together.

Software starts the channel with a start request. A stop request takes effect only when the current period ends, and the running flag stays high until then.

Top module: `pwm_buffered_channel`

## Requirements
- R1: After reset, pwm_out, running and upd_evt are all 0, and the mode, compare and period registers are 0.
- R2: The register addresses are: 0x00 mode, 0x04 active compare, 0x08 compare shadow, 0x0C active period, 0x10 period shadow. In the mode word, bits 3:0 are the prescaler p, bit 9 is polarity and bit 10 is the linked bit. While the channel is stopped, a write to an active register takes effect on the next clock. A write to any other address changes nothing.
- R3: The counter advances once every 2^p clocks, where p is the prescaler and values above 10 act as 10. One period lasts (period register) × 2^p clocks. Within each period the output is active while count ≥ compare, which gives (period − compare) × 2^p active clocks.
- R4: With polarity 0 the active level is 1. With polarity 1 the active level is 0. The polarity bit takes effect on the clock after it is written, even while the channel runs.
- R5: While running is 0, pwm_out sits at the inactive level: 0 for polarity 0 and 1 for polarity 1.
- R6: A compare value of 0 keeps the output active for the whole period. A compare value greater than or equal to the period keeps it inactive for the whole period.
- R7: A value written to a shadow register while the channel runs reaches the active register only at the end of the current period. The period in which it was written still uses the old value.
- R8: Each period boundary at which at least one shadow value is moved raises upd_evt for exactly one clock, in the cycle that follows the boundary. No event occurs while the channel is stopped.
- R9: With the linked bit set, a pending shadow value is held back until the other shadow register has also been written. Both then move at the same boundary with a single event.
- R10: A start request while stopped sets running on the next clock. A stop request leaves running at 1 until the end of the current period and clears it at that boundary.
- R11: While the channel runs, writes to the active compare and period registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| start_req | input | 1 | Start request pulse |
| stop_req | input | 1 | Stop request pulse (honoured at period end) |
| pwm_out | output | 1 | Waveform output |
| running | output | 1 | Channel is generating a waveform |
| upd_evt | output | 1 | One-cycle pulse after a shadow-to-active transfer |

## Verification
The active-cycle count is measured over windows whose length is a multiple of the period. These measurements are taken for several ratios:
- a 3-of-10 compare with and without inversion, which separates the polarity handling from the compare itself;
- prescaler 2 with a 5-count period, which exposes a wrong divider or a wrong tick alignment;
- compare values of 0, equal to the period and above the period, which exercise both ends of the comparison.

A shadow write placed in the first cycle of a period checks that the remaining cycles of that period still follow the old compare. The event count then tells a boundary transfer apart from an immediate one. In linked mode, a lone compare write must leave both the ratio and the event count unchanged until the period write arrives. A stop issued in the first cycle of a period must keep running high for exactly the rest of that period.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned PRE_W   = 4;
  localparam int unsigned PRE_MAX = 10;

  localparam logic [ADDR_W-1:0] A_MODE     = 5'h00;
  localparam logic [ADDR_W-1:0] A_CMP      = 5'h04;
  localparam logic [ADDR_W-1:0] A_CMP_SH   = 5'h08;
  localparam logic [ADDR_W-1:0] A_PER      = 5'h0C;
  localparam logic [ADDR_W-1:0] A_PER_SH   = 5'h10;

  localparam int unsigned MODE_POL_BIT  = 9;
  localparam int unsigned MODE_LINK_BIT = 10;

  typedef struct packed {
    logic             link;
    logic             pol;
    logic [PRE_W-1:0] pre;
  } mode_t;
endpackage

// File: rtl/pwmch_rst_sync.sv
module pwmch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pwmch_regs.sv
module pwmch_regs
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              running,
  input  logic              period_end,
  output mode_t             mode,
  output logic [CNT_W-1:0]  cmp_act,
  output logic [CNT_W-1:0]  per_act,
  output logic              upd_evt
);
  mode_t            mode_q,   mode_d;
  logic [CNT_W-1:0] cmp_q,    cmp_d;
  logic [CNT_W-1:0] per_q,    per_d;
  logic [CNT_W-1:0] cmp_sh_q, cmp_sh_d;
  logic [CNT_W-1:0] per_sh_q, per_sh_d;
  logic             cmp_pend_q, cmp_pend_d;
  logic             per_pend_q, per_pend_d;
  logic             evt_q, evt_d;

  logic wr_mode, wr_cmp, wr_cmp_sh, wr_per, wr_per_sh;
  logic boundary, xfer_cmp, xfer_per;
  logic mode_unused;

  assign mode_unused = ^{wdata[CNT_W-1:MODE_LINK_BIT+1], wdata[MODE_POL_BIT-1:PRE_W]};

  always_comb begin
    wr_mode   = we && (addr == A_MODE);
    wr_cmp    = we && (addr == A_CMP);
    wr_cmp_sh = we && (addr == A_CMP_SH);
    wr_per    = we && (addr == A_PER);
    wr_per_sh = we && (addr == A_PER_SH);

    boundary  = running && period_end;
    xfer_cmp  = boundary && cmp_pend_q && (!mode_q.link || per_pend_q);
    xfer_per  = boundary && per_pend_q && (!mode_q.link || cmp_pend_q);

    mode_d = mode_q;
    if (wr_mode) begin
      mode_d.link = wdata[MODE_LINK_BIT];
      mode_d.pol  = wdata[MODE_POL_BIT];
      mode_d.pre  = wdata[PRE_W-1:0];
    end

    cmp_d = cmp_q;
    if (xfer_cmp)               cmp_d = cmp_sh_q;
    else if (wr_cmp && !running) cmp_d = wdata;

    per_d = per_q;
    if (xfer_per)               per_d = per_sh_q;
    else if (wr_per && !running) per_d = wdata;

    cmp_sh_d = wr_cmp_sh ? wdata : cmp_sh_q;
    per_sh_d = wr_per_sh ? wdata : per_sh_q;

    cmp_pend_d = (cmp_pend_q && !xfer_cmp) || wr_cmp_sh;
    per_pend_d = (per_pend_q && !xfer_per) || wr_per_sh;

    evt_d = xfer_cmp || xfer_per;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      cmp_q      <= '0;
      per_q      <= '0;
      cmp_sh_q   <= '0;
      per_sh_q   <= '0;
      cmp_pend_q <= 1'b0;
      per_pend_q <= 1'b0;
      evt_q      <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      cmp_q      <= cmp_d;
      per_q      <= per_d;
      cmp_sh_q   <= cmp_sh_d;
      per_sh_q   <= per_sh_d;
      cmp_pend_q <= cmp_pend_d;
      per_pend_q <= per_pend_d;
      evt_q      <= evt_d;
    end
  end

  assign mode    = mode_q;
  assign cmp_act = cmp_q;
  assign per_act = per_q;
  assign upd_evt = evt_q;

  // R7 / R11: active values only move at a boundary while running
  assert_active_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running && !period_end |=> $stable(cmp_act) && $stable(per_act));

  // R8: no transfer event follows a stopped cycle
  assert_no_evt_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !upd_evt);
endmodule

// File: rtl/pwmch_timebase.sv
module pwmch_timebase
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic [PRE_W-1:0] pre,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             period_end
);
  localparam int unsigned DIV_W = PRE_MAX;

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] mask;
  logic [PRE_W-1:0] pre_eff;
  logic             tick;

  always_comb begin
    pre_eff = (pre > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : pre;
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (32'(i) < 32'(pre_eff));
    end
    tick       = running && ((div_q & mask) == mask);
    period_end = tick &&
                 (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, per_act});

    div_d = running ? (div_q + DIV_W'(1)) : '0;

    if (!running || period_end) cnt_d = '0;
    else if (tick)              cnt_d = cnt_q + CNT_W'(1);
    else                        cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R3: the count never reaches the period value
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < per_act));

  // R3: a stopped channel restarts its count from zero
  assert_cnt_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt_q == '0));
endmodule

// File: rtl/pwmch_runctl.sv
module pwmch_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic period_end,
  output logic running
);
  logic run_q, run_d;
  logic stop_pend_q, stop_pend_d;

  always_comb begin
    if (!run_q)                                      run_d = start_req;
    else if (period_end && (stop_pend_q || stop_req)) run_d = 1'b0;
    else                                             run_d = 1'b1;

    if (!run_q || period_end) stop_pend_d = 1'b0;
    else                      stop_pend_d = stop_pend_q || stop_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      run_q       <= run_d;
      stop_pend_q <= stop_pend_d;
    end
  end

  assign running = run_q;

  // R10: a running channel stops only at a period boundary
  assert_stop_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !period_end |=> run_q);

  // R10: a start request on a stopped channel takes effect next clock
  assert_start_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && start_req |=> run_q);

  // R10: without a start request a stopped channel stays stopped
  assert_stay_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !start_req |=> !run_q);
endmodule

// File: rtl/pwmch_wave.sv
module pwmch_wave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             running,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             wave
);
  logic active;

  always_comb begin
    active = (cnt >= cmp_act);
    wave   = running ? (active ^ pol) : pol;
  end
endmodule

// File: rtl/pwm_buffered_channel.sv
module pwm_buffered_channel
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic              start_req,
  input  logic              stop_req,
  output logic              pwm_out,
  output logic              running,
  output logic              upd_evt
);
  logic             rst_n_i;
  mode_t            mode;
  logic [CNT_W-1:0] cmp_act, per_act, cnt;
  logic             period_end;

  pwmch_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pwmch_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .running    (running),
    .period_end (period_end),
    .mode       (mode),
    .cmp_act    (cmp_act),
    .per_act    (per_act),
    .upd_evt    (upd_evt)
  );

  pwmch_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .running    (running),
    .pre        (mode.pre),
    .per_act    (per_act),
    .cnt        (cnt),
    .period_end (period_end)
  );

  pwmch_runctl u_run (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .period_end (period_end),
    .running    (running)
  );

  pwmch_wave #(.CNT_W(CNT_W)) u_wave (
    .running (running),
    .pol     (mode.pol),
    .cnt     (cnt),
    .cmp_act (cmp_act),
    .wave    (pwm_out)
  );

  // R5: the output rests at the inactive level while stopped
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    !running |-> (pwm_out == mode.pol));
endmodule

// File: tb/pwm_buffered_channel_tb_top.sv
module pwm_buffered_channel_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        start_req;
  logic        stop_req;
  logic        pwm_out;
  logic        running;
  logic        upd_evt;

  int n_chk;
  int n_bad;
  int run_cyc;
  int evt_cnt;

  pwm_buffered_channel dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .start_req (start_req),
    .stop_req  (stop_req),
    .pwm_out   (pwm_out),
    .running   (running),
    .upd_evt   (upd_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (running) run_cyc <= run_cyc + 1;
    if (upd_evt) evt_cnt <= evt_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  task automatic stop_and_wait(input string req);
    int k;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    k = 0;
    while (running && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(req, int'(running), 0);
  endtask

  task automatic t_reset();
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 upd_evt", int'(upd_evt), 0);
  endtask

  task automatic t_idle_level();
    wr(5'h0C, 16'd10);
    wr(5'h04, 16'd3);
    wr(5'h00, 16'h0200);
    chk("R5 idle level inverted", int'(pwm_out), 1);
    wr(5'h00, 16'h0000);
    chk("R5 idle level normal", int'(pwm_out), 0);
  endtask

  task automatic t_basic_and_stop();
    int hi, base;
    base = run_cyc;
    pulse_start();
    chk("R10 running after start", int'(running), 1);
    count_high(100, hi);
    chk("R3 ratio 3/10", hi, 70);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R10 still running after stop request", int'(running), 1);
    repeat (8) @(negedge clk);
    chk("R10 running on last cycle of period", int'(running), 1);
    @(negedge clk);
    chk("R10 stopped at boundary", int'(running), 0);
    chk("R10 running cycles", run_cyc - base, 110);
  endtask

  task automatic t_ignore_active();
    int hi;
    pulse_start();
    wr(5'h04, 16'd0);
    wr(5'h0C, 16'd4);
    wr(5'h14, 16'hFFFF);
    count_high(100, hi);
    chk("R11 active writes ignored while running", hi, 70);
    stop_and_wait("R10 stop after ignore test");
    wr(5'h1C, 16'd1);
    pulse_start();
    count_high(100, hi);
    chk("R2 unmapped write ignored", hi, 70);
    stop_and_wait("R10 stop after unmapped test");
  endtask

  task automatic t_polarity();
    int hi;
    pulse_start();
    wr(5'h00, 16'h0200);
    count_high(100, hi);
    chk("R4 inverted ratio", hi, 30);
    stop_and_wait("R10 stop after polarity test");
    chk("R5 idle high when inverted", int'(pwm_out), 1);
    wr(5'h00, 16'h0000);
    chk("R4 normal idle level", int'(pwm_out), 0);
  endtask

  task automatic t_prescale();
    int hi, base;
    wr(5'h00, 16'h0002);
    wr(5'h0C, 16'd5);
    wr(5'h04, 16'd1);
    base = run_cyc;
    pulse_start();
    count_high(100, hi);
    chk("R3 prescaled ratio", hi, 80);
    stop_and_wait("R10 stop after prescale test");
    chk("R3 prescaled period length", run_cyc - base, 120);
    wr(5'h00, 16'h0000);
  endtask

  task automatic t_extremes();
    int hi;
    wr(5'h0C, 16'd10);
    wr(5'h04, 16'd0);
    pulse_start();
    count_high(50, hi);
    chk("R6 compare zero always active", hi, 50);
    stop_and_wait("R10 stop after compare zero");
    wr(5'h04, 16'd10);
    pulse_start();
    count_high(50, hi);
    chk("R6 compare equal period never active", hi, 0);
    stop_and_wait("R10 stop after compare equal");
    wr(5'h04, 16'd12);
    pulse_start();
    count_high(50, hi);
    chk("R6 compare above period never active", hi, 0);
    stop_and_wait("R10 stop after compare above");
  endtask

  task automatic t_buffered();
    int hi, ev0;
    wr(5'h04, 16'd3);
    ev0 = evt_cnt;
    pulse_start();
    wr(5'h08, 16'd8);
    count_high(9, hi);
    chk("R7 old compare kept until boundary", hi, 7);
    count_high(100, hi);
    chk("R7 new compare after boundary", hi, 20);
    chk("R8 one event per transfer", evt_cnt - ev0, 1);
    wr(5'h10, 16'd20);
    repeat (20) @(negedge clk);
    count_high(100, hi);
    chk("R7 new period after boundary", hi, 60);
    chk("R8 second event", evt_cnt - ev0, 2);
  endtask

  task automatic t_linked();
    int hi, ev0;
    ev0 = evt_cnt;
    wr(5'h00, 16'h0400);
    wr(5'h08, 16'd5);
    repeat (30) @(negedge clk);
    count_high(100, hi);
    chk("R9 lone compare held in linked mode", hi, 60);
    chk("R9 no event for lone write", evt_cnt - ev0, 0);
    wr(5'h10, 16'd10);
    repeat (30) @(negedge clk);
    count_high(100, hi);
    chk("R9 pair moved together", hi, 50);
    chk("R9 single event for pair", evt_cnt - ev0, 1);
    stop_and_wait("R10 final stop");
    ev0 = evt_cnt;
    repeat (20) @(negedge clk);
    chk("R8 no event while stopped", evt_cnt - ev0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; run_cyc = 0; evt_cnt = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    start_req = 1'b0; stop_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_idle_level();
    t_basic_and_stop();
    t_ignore_active();
    t_polarity();
    t_prescale();
    t_extremes();
    t_buffered();
    t_linked();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule